// File: doc/BRIEF.md
# Baud and Sample Tick Generator

This block derives the two timing strobes a serial receiver and transmitter need from a single system clock. A programmable down-counter divides the clock by an integer C and emits a one-cycle sample tick once every C clocks. The receiver uses these sample ticks directly, so it samples the line many times per bit. A fixed prescaler then divides the sample ticks by the oversampling factor OVS to form a bit tick for the transmitter. The resulting bit rate is f/(OVS·C). The highest bit rate the receiver can follow is therefore 1/OVS of the sample rate.

Software writes the divisor as C−1. The counter counts down through zero and then reloads that value. A write takes effect at once. It reloads the counter and clears the prescaler, so the first period after a rate change is a full, correct period and never a leftover fragment of the old rate.

Top module: `uart_tick_gen`

## Requirements
- R1: While reset is low, both ticks are low. After reset the divisor equals parameter RST_DIV, and the first sample tick appears in the cycle after the (RST_DIV+1)-th rising edge following reset release.
- R2: With divisor value D held, sample ticks repeat exactly every D+1 clock cycles and each tick lasts one cycle.
- R3: With divisor value 0, the sample tick is high on every cycle after the first edge that follows the write.
- R4: The bit tick is high on every OVS-th sample tick, counted from reset or from the last write, and only in a cycle where the sample tick is also high.
- R5: A write of value V in a cycle forces both ticks low in the following cycle. The next sample tick then appears V+1 cycles after the write edge, and the prescaler restarts its count from zero.
- R6: The bit tick is a single-cycle pulse. It is never high in two consecutive cycles.
- R7: A written divisor value is kept until the next write, so the sample period stays at V+1 over arbitrarily many periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Divisor value to write (C−1) |
| samp_tick | output | 1 | One-cycle pulse at the oversampled rate, for the receiver |
| bit_tick | output | 1 | One-cycle pulse at the bit rate, for the transmitter |

## Verification
The hardest case to reach is a divisor write that lands in the exact cycle when a sample tick, or a bit tick, would have fired. In that case the write must win, and the prescaler must restart from zero in the middle of its count. The stimulus sweeps the write through every phase of a short sample period and through several positions within a prescaler cycle. It also issues back-to-back writes. A behavioural model, which counts edges since the last write, predicts both ticks on every clock.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;
    // Default width of the divisor register (holds C-1)
    localparam int DEF_DIV_W   = 12;
    // Default oversampling factor: sample ticks per bit
    localparam int DEF_OVS     = 16;
    // Default divisor loaded at reset (C = 10)
    localparam int DEF_RST_DIV = 9;
endpackage

// File: rtl/tick_div_reg.sv
// tick_div_reg: holds the programmed divisor value (C-1).
// Assumes writes are single-cycle strobes; the value persists until rewritten.
module tick_div_reg #(
    parameter int DIV_W   = 12,
    parameter int RST_DIV = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] div_q
);
    // Capture the divisor on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= DIV_W'(RST_DIV);
        else if (wr)
            div_q <= wdata;
    end
endmodule

// File: rtl/tick_samp_cnt.sv
// tick_samp_cnt: down-counter that emits one sample tick every reload+1 clocks.
// Assumes a write loads the new value straight into the counter and
// suppresses the tick of that cycle; samp_ev marks the edge a tick is issued.
module tick_samp_cnt #(
    parameter int DIV_W   = 12,
    parameter int RST_DIV = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    input  logic [DIV_W-1:0] reload,
    output logic             samp_ev,
    output logic             samp_tick
);
    logic [DIV_W-1:0] cnt_q;

    // A tick is due when the counter sits at zero and no write overrides it
    assign samp_ev = !wr && (cnt_q == '0);

    // Count down through zero, reload, and register the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= DIV_W'(RST_DIV);
            samp_tick <= 1'b0;
        end else if (wr) begin
            cnt_q     <= wdata;
            samp_tick <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q     <= reload;
            samp_tick <= 1'b1;
        end else begin
            cnt_q     <= cnt_q - 1'b1;
            samp_tick <= 1'b0;
        end
    end
endmodule

// File: rtl/tick_prescale.sv
// tick_prescale: divides sample events by OVS to form the bit tick.
// Assumes OVS >= 2; a write clears the count so a new rate starts a full bit.
module tick_prescale #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic samp_ev,
    output logic bit_tick
);
    localparam int               PC_W = (OVS > 2) ? $clog2(OVS) : 1;
    localparam logic [PC_W-1:0]  LAST = PC_W'(OVS - 1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_next;
    logic            at_last;

    assign at_last = (pc_q == LAST);

    generate
        if ((1 << PC_W) == OVS) begin : g_pow2
            // Natural wrap when OVS is a power of two
            assign pc_next = pc_q + 1'b1;
        end else begin : g_any
            // Explicit wrap for other factors
            assign pc_next = at_last ? '0 : pc_q + 1'b1;
        end
    endgenerate

    // Count sample events and pulse on the last of each group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            bit_tick <= 1'b0;
        end else if (wr) begin
            pc_q     <= '0;
            bit_tick <= 1'b0;
        end else if (samp_ev) begin
            pc_q     <= pc_next;
            bit_tick <= at_last;
        end else begin
            bit_tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tick_gen.sv
// uart_tick_gen: sample-rate and bit-rate tick generator for a serial port.
// Assumes a synchronous active-low reset and single-cycle divisor writes.
module uart_tick_gen
    import uart_tick_pkg::*;
#(
    parameter int DIV_W   = DEF_DIV_W,
    parameter int OVS     = DEF_OVS,
    parameter int RST_DIV = DEF_RST_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             samp_tick,
    output logic             bit_tick
);
    logic [DIV_W-1:0] div_q;
    logic             samp_ev;

    tick_div_reg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(div_wr), .wdata(div_wdata), .div_q(div_q)
    );

    tick_samp_cnt #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr(div_wr), .wdata(div_wdata),
        .reload(div_q), .samp_ev(samp_ev), .samp_tick(samp_tick)
    );

    tick_prescale #(.OVS(OVS)) u_pre (
        .clk(clk), .rst_n(rst_n), .wr(div_wr), .samp_ev(samp_ev), .bit_tick(bit_tick)
    );
endmodule

// File: rtl/uart_tick_gen_chk.sv
// uart_tick_gen_chk: port-level properties of the tick generator.
// Tracks edges since the last write or reset and the last written divisor.
module uart_tick_gen_chk #(
    parameter int DIV_W   = 12,
    parameter int RST_DIV = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_wr,
    input logic [DIV_W-1:0] div_wdata,
    input logic             samp_tick,
    input logic             bit_tick
);
    logic [31:0]      edges_q;
    logic [DIV_W-1:0] shadow_q;
    logic [31:0]      cur_c;

    assign cur_c = 32'(shadow_q) + 32'd1;

    // Observe the write stream from the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q  <= '0;
            shadow_q <= DIV_W'(RST_DIV);
        end else if (div_wr) begin
            edges_q  <= '0;
            shadow_q <= div_wdata;
        end else begin
            edges_q  <= edges_q + 32'd1;
        end
    end

    // R1
    a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |=> !samp_tick && !bit_tick);
    // R2
    a_r2_tick_on_period: assert property (@(posedge clk) disable iff (!rst_n)
        samp_tick |-> (edges_q != 0) && ((edges_q % cur_c) == 0));
    // R3
    a_r3_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q == '0) && (edges_q != 0) |-> samp_tick);
    // R4
    a_r4_bit_with_samp: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> samp_tick);
    // R5
    a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> !samp_tick && !bit_tick);
    // R6
    a_r6_bit_single: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

bind uart_tick_gen uart_tick_gen_chk #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) i_chk (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .samp_tick(samp_tick), .bit_tick(bit_tick)
);

// File: tb/test_uart_tick_gen.sv
module test_uart_tick_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 12;
    localparam int OVS        = 16;
    localparam int RST_DIV    = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             samp_tick;
    logic             bit_tick;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int n      = 0;     // edges since last write or reset
    int cval   = RST_DIV + 1;
    bit from_reset = 1'b1;
    int samp_cnt = 0;
    int bit_hi   = 0;
    int bit_rise = 0;
    bit prev_bit = 1'b0;
    bit done = 1'b0;

    uart_tick_gen #(.DIV_W(DIV_W), .OVS(OVS), .RST_DIV(RST_DIV)) i_uart_tick_gen (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
        .samp_tick(samp_tick), .bit_tick(bit_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cycles, act, exp);
        end
    endtask

    // Behavioural reference: predict from edges since last write
    always @(posedge clk) begin
        bit wr_s;
        int wd_s;
        bit rs_s;
        bit e_samp;
        bit e_bit;
        string rq;
        wr_s = div_wr;
        wd_s = int'(div_wdata);
        rs_s = rst_n;
        #1;
        cycles++;
        if (!rs_s) begin
            n = 0; cval = RST_DIV + 1; from_reset = 1'b1;
        end else if (wr_s) begin
            n = 0; cval = wd_s + 1; from_reset = 1'b0;
        end else begin
            n++;
        end
        e_samp = (n > 0) && (n % cval == 0);
        e_bit  = e_samp && ((n / cval) % OVS == 0);
        if (!rs_s)                rq = "R1";
        else if (cval == 1)       rq = "R3";
        else if (n <= cval)       rq = from_reset ? "R1" : "R5";
        else                      rq = "R2";
        check({rq, " samp_tick"}, int'(samp_tick), int'(e_samp));
        check((n <= cval * OVS && !from_reset) ? "R5 bit_tick" : "R4 bit_tick",
              int'(bit_tick), int'(e_bit));
        if (samp_tick) samp_cnt++;
        if (bit_tick) bit_hi++;
        if (bit_tick && !prev_bit) bit_rise++;
        prev_bit = bit_tick;
    end

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic wr_div(input int v);
        @(negedge clk);
        div_wr = 1'b1; div_wdata = DIV_W'(v);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        check("R1 reset samp", int'(samp_tick), 0);
        idle(3);
        check("R1 reset bit", int'(bit_tick), 0);
        rst_n = 1'b1;
        idle(400);
        wr_div(0);                    // R3
        idle(40);
        wr_div(4);
        idle(200);
        for (int ph = 0; ph < 7; ph++) begin   // write at every phase of a 3-cycle period
            wr_div(2);
            idle(ph);
        end
        idle(60);
        for (int ph = 0; ph < 5; ph++) begin   // write at varied prescaler positions
            wr_div(1);
            idle(5 + ph * 7);
        end
        @(negedge clk); div_wr = 1'b1; div_wdata = DIV_W'(3);
        @(negedge clk); div_wdata = DIV_W'(6);
        @(negedge clk); div_wr = 1'b0;         // back-to-back writes
        idle(300);
        wr_div(5);
        idle(1000);
        samp_cnt = 0;
        idle(600);
        check("R7 held divisor tick count", samp_cnt, 100);
        wr_div(200);
        idle(3400);
        check("R6 bit pulses single-cycle", bit_hi, bit_rise);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule